// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave with Persistent Pointer

This block is a slave on a two-wire serial bus (clock line and open-drain data line). It oversamples both lines on the system clock and decodes START and STOP conditions. It answers one device address, formed from a fixed four-bit type code and three strap inputs, and it holds a byte array. The slave never drives the data line high: it pulls the line low through an output enable, and an external pull-up provides the high level.

A persistent address pointer sets where reads and writes land. A write transaction sends two word-address bytes, which load the pointer, and may then send data bytes. Each data byte is stored at the pointer. The pointer then advances inside its page, and the page number does not change. A read transaction that sends no word address returns the byte at the pointer ("current address read"). A random read is a word-address write followed by a repeated START and a read. While the master acknowledges each byte, the read continues through the array and carries across page boundaries. The pointer keeps its value between transactions, so a later read with no word address continues from the last access.

The default array is 1024 bytes. Setting the address width to 14 gives a 16K-byte array with an 8-bit page number.

Top module: `eeprom_2w_slave`

## Requirements
- R1: A byte received after START whose upper seven bits equal 1010 followed by `strap_i[2:0]` (MSB first) is acknowledged: the slave pulls SDA low during the ninth clock. Bit 0 of that byte selects read (1) or write (0).
- R2: A device byte with any other upper seven bits is not acknowledged. The slave then leaves SDA released until the next START, and the pointer is unchanged.
- R3: In a write, the first two bytes after the device byte are the word address, upper byte first, and each is acknowledged. They load the pointer with the low ADDR_W bits of the 16-bit value, and any bits above ADDR_W are ignored.
- R4: Each further write byte is acknowledged and stored at the pointer. The low PAGE_W bits of the pointer then increment and wrap from all-ones to zero, and the upper bits do not change.
- R5: A read sends the byte at the pointer MSB first, one bit per SCL clock. After the eighth bit, the pointer increments with full carry, wrapping from the last address to 0.
- R6: The pointer keeps its value across STOP. A read with no word address sent starts at the pointer left by the previous read or write.
- R7: If the master acknowledges a read byte, the next byte follows. If the master does not acknowledge, the slave keeps SDA released for the rest of the transaction.
- R8: START and STOP are SDA falling and rising edges while SCL is high. A START in any state, including a repeated START, restarts device-address reception.
- R9: The slave asserts its SDA drive only in response to SCL falling, never while SCL is high.
- R10: After reset, SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Strap bits matched against device address bits 3..1 |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
On every cycle, the assertions check that the drive enable is asserted only after an SCL fall (R9) and that the slave is silent when idle or deselected (R2). They also check the page-limited step of the pointer after each stored byte (R4) and the full-carry step after each byte sent (R5). Only the bench scenarios show the values that travel over the bus: byte contents, pointer persistence across STOP, random read through a repeated START, read wrap at the top of the array, and the upper word-address bits being ignored. The bench compares these against its own model of the array and pointer.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_WHI, ST_WLO, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK
    } ee_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/ee2w_bus_sense.sv
module ee2w_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES:0] scl_pipe_q, scl_pipe_d;
    logic [SYNC_STAGES:0] sda_pipe_q, sda_pipe_d;
    logic scl_prev, sda_prev;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[SYNC_STAGES-1:0], scl_i};
        sda_pipe_d = {sda_pipe_q[SYNC_STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
        end
    end

    assign scl_lvl   = scl_pipe_q[SYNC_STAGES-1];
    assign sda_lvl   = sda_pipe_q[SYNC_STAGES-1];
    assign scl_prev  = scl_pipe_q[SYNC_STAGES];
    assign sda_prev  = sda_pipe_q[SYNC_STAGES];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/ee2w_byte_array.sv
module ee2w_byte_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[addr] <= wr_data;
    end

    assign rd_data = cells[addr];
endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);
    import ee2w_pkg::*;

    typedef struct packed {
        ee_state_e         st;
        ee_state_e         nxt;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [7:0]        tx;
        logic [7:0]        hi;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              mack;
    } regs_t;

    regs_t q, d;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [7:0] rd_data;
    logic [PAGE_W-1:0] page_inc;

    ee2w_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    ee2w_byte_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .wr_en(wr_en), .addr(q.ptr), .wr_data(q.sh), .rd_data(rd_data)
    );

    assign page_inc = q.ptr[PAGE_W-1:0] + 1'b1;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (start_det) begin
            d.st  = ST_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_DEV, ST_WHI, ST_WLO, ST_WDAT: begin
                    if (scl_rise && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.oe  = 1'b1;
                        d.st  = ST_ACK;
                        case (q.st)
                            ST_DEV: begin
                                if (q.sh[7:1] == {DEV_TYPE, strap_i}) begin
                                    d.nxt = q.sh[0] ? ST_RDAT : ST_WHI;
                                end else begin
                                    d.st = ST_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                            ST_WHI: begin
                                d.hi  = q.sh;
                                d.nxt = ST_WLO;
                            end
                            ST_WLO: begin
                                d.ptr = ADDR_W'({q.hi, q.sh});
                                d.nxt = ST_WDAT;
                            end
                            default: begin
                                wr_en = 1'b1;
                                d.ptr = {q.ptr[ADDR_W-1:PAGE_W], page_inc};
                                d.nxt = ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        d.st  = q.nxt;
                        if (q.nxt == ST_RDAT) begin
                            d.oe = ~rd_data[7];
                            d.tx = {rd_data[6:0], 1'b0};
                        end else begin
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + 1'b1;
                            d.st  = ST_RACK;
                        end else begin
                            d.oe = ~q.tx[7];
                            d.tx = {q.tx[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.st = ST_RDAT;
                            d.oe = ~rd_data[7];
                            d.tx = {rd_data[6:0], 1'b0};
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, nxt: ST_IDLE, cnt: '0, sh: '0, tx: '0,
                   hi: '0, ptr: '0, oe: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    assert_drive_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !$past(scl_lvl));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);

    assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q.ptr[ADDR_W-1:PAGE_W] == $past(q.ptr[ADDR_W-1:PAGE_W]))
               && (q.ptr[PAGE_W-1:0] == PAGE_W'($past(q.ptr[PAGE_W-1:0]) + 1'b1)));

    assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RDAT && scl_fall && q.cnt == 4'd8 && !start_det && !stop_det)
        |=> q.ptr == ADDR_W'($past(q.ptr) + 1'b1));
endmodule

// File: tb/eeprom_2w_slave_tb.sv
module eeprom_2w_slave_tb_top;
    localparam int AW = 10;
    localparam int PW = 6;
    localparam int AMASK = (1 << AW) - 1;
    localparam int PMASK = (1 << PW) - 1;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    eeprom_2w_slave #(.ADDR_W(AW), .PAGE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(STRAP), .sda_oe_o(sda_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    int r9_bad = 0;
    int quiet_bad = 0;
    logic quiet = 1'b0;
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    bit finished = 0;

    logic [7:0] ref_mem [int];
    int ref_ptr = 0;

    // per-clock comparison against the bench's expectations of bus behaviour
    always @(negedge clk) begin
        if (rst_n && sda_oe && !prev_oe && scl && prev_scl) r9_bad++;
        if (rst_n && quiet && sda_oe) quiet_bad++;
        prev_oe  <= sda_oe;
        prev_scl <= scl;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic got);
        wait_clk(5); sda_m = b;
        wait_clk(5); scl = 1'b1;
        wait_clk(5); got = sda_line;
        wait_clk(5); scl = 1'b0;
    endtask

    task automatic bus_start();
        wait_clk(5); sda_m = 1'b1;
        wait_clk(5); scl = 1'b1;
        wait_clk(5); sda_m = 1'b0;
        wait_clk(5); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(5); sda_m = 1'b0;
        wait_clk(5); scl = 1'b1;
        wait_clk(5); sda_m = 1'b1;
        wait_clk(10);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic got;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], got);
        bit_cycle(1'b1, got);
        check(got == !exp_ack, tag, int'(got), int'(!exp_ack));
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic got;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, got);
            v[i] = got;
        end
        bit_cycle(!mack, got);
    endtask

    function automatic logic [7:0] dev(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic m_set(input logic [7:0] hi, input logic [7:0] lo);
        ref_ptr = {hi, lo} & AMASK;
    endtask

    task automatic m_write(input logic [7:0] b);
        ref_mem[ref_ptr] = b;
        ref_ptr = (ref_ptr & ~PMASK) | ((ref_ptr + 1) & PMASK);
    endtask

    task automatic m_read(output logic [7:0] b);
        b = ref_mem[ref_ptr];
        ref_ptr = (ref_ptr + 1) & AMASK;
    endtask

    // full write transaction: word address then data bytes
    task automatic do_write(input logic [7:0] hi, input logic [7:0] lo,
                            input logic [7:0] data[$]);
        bus_start();
        send_byte(dev(STRAP, 1'b0), 1'b1, "R1 write select ack");
        send_byte(hi, 1'b1, "R3 word addr hi ack");
        send_byte(lo, 1'b1, "R3 word addr lo ack");
        m_set(hi, lo);
        foreach (data[k]) begin
            send_byte(data[k], 1'b1, "R4 data ack");
            m_write(data[k]);
        end
        bus_stop();
    endtask

    // read n bytes from the current pointer, master ACKs all but last
    task automatic read_run(input int n, input string tag);
        logic [7:0] v, e;
        send_byte(dev(STRAP, 1'b1), 1'b1, "R1 read select ack");
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            m_read(e);
            check(v == e, tag, int'(v), int'(e));
        end
    endtask

    task automatic random_read(input logic [7:0] hi, input logic [7:0] lo,
                               input int n, input string tag);
        bus_start();
        send_byte(dev(STRAP, 1'b0), 1'b1, "R1 write select ack");
        send_byte(hi, 1'b1, "R3 word addr hi ack");
        send_byte(lo, 1'b1, "R3 word addr lo ack");
        m_set(hi, lo);
        bus_start();   // repeated START, R8
        read_run(n, tag);
        bus_stop();
    endtask

    initial begin
        logic [7:0] q[$];
        logic got;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        check(sda_oe == 1'b0, "R10 released after reset", int'(sda_oe), 0);
        ref_ptr = 0;

        q = '{8'hAA, 8'hBB, 8'hCC, 8'hDD};
        do_write(8'h00, 8'h10, q);
        q = '{8'h77};
        do_write(8'h00, 8'h40, q);

        // R8 R5 R7: random sequential read via repeated START
        random_read(8'h00, 8'h10, 3, "R5 R8 sequential random read");
        check(sda_oe == 1'b0, "R7 released after NACK", int'(sda_oe), 0);

        // R6: pointer loaded by address-only write persists across STOP
        bus_start();
        send_byte(dev(STRAP, 1'b0), 1'b1, "R1 write select ack");
        send_byte(8'h00, 1'b1, "R3 word addr hi ack");
        send_byte(8'h11, 1'b1, "R3 word addr lo ack");
        m_set(8'h00, 8'h11);
        bus_stop();
        bus_start(); read_run(1, "R6 current read after addr write"); bus_stop();
        bus_start(); read_run(1, "R6 current read continues"); bus_stop();

        // R2: mismatched strap bits, then bus is left alone
        bus_start();
        send_byte(dev(3'b011, 1'b1), 1'b0, "R2 mismatch not acked");
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) bit_cycle(1'b1, got);
        bus_stop();
        quiet = 1'b0;
        check(quiet_bad == 0, "R2 SDA untouched after mismatch", quiet_bad, 0);
        bus_start(); read_run(1, "R2 pointer unchanged by mismatch"); bus_stop();

        // R4: page wrap within a write, upper bits frozen
        q = '{8'h11, 8'h22, 8'h33};
        do_write(8'h00, 8'h3E, q);
        random_read(8'h00, 8'h00, 1, "R4 page wrap landed at page start");
        random_read(8'h00, 8'h3F, 2, "R5 read carries across page");

        // R3 ignored upper bits; R5 rollover at last address
        q = '{8'h5A};
        do_write(8'hFF, 8'hFF, q);
        random_read(8'h03, 8'hFF, 2, "R3 R5 top address and rollover");

        // R6: write then current read continues at write pointer
        q = '{8'hE1, 8'hE2};
        do_write(8'h01, 8'h20, q);
        random_read(8'h01, 8'h20, 1, "R4 stored byte");
        bus_start(); read_run(1, "R6 current read after random read"); bus_stop();

        check(r9_bad == 0, "R9 no drive rise while SCL high", r9_bad, 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule